// File: doc/BRIEF.md
# Deadbeat Adaptive Loop Filter for Audio Clock Recovery

This block is the digital loop filter of an audio clock-recovery loop. Each time the phase detector presents a new signed phase error together with a sample strobe, the filter updates a 24-bit control word for a digitally controlled oscillator. In its base mode the filter is deadbeat. After a step in the reference period it produces a single corrective overshoot on the next sample, and from the sample after that it is locked in both frequency and phase.

The filter is built from two halves. An integrator (the frequency estimate) accumulates every applied error. A phase stage takes the previous integrator value and adds twice the applied error. Once the error has stayed small for several evaluations in a row, the filter stretches its evaluation interval by a power of two, up to 16. Between evaluations the control word is frozen and the raw errors are only summed. At each evaluation that sum is divided by the interval factor with an arithmetic right shift. Any sample whose error magnitude reaches the threshold forces the filter straight back to per-sample operation.

Top module: `tofl_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `ctrl_word` equals `centre`, `interval_n` equals 1 and `locked` is 0.
- R2: With `interval_n` = 1 and a sub-threshold error e(k) strobed, the `ctrl_word` registered at that clock edge is u(k) = u(k−1) + 2·e(k) − e(k−1). In a cycle without `smp_valid`, `ctrl_word`, `interval_n` and `locked` keep their values whatever `err_in` carries.
- R3: Start from a settled loop at control word T1. A strobed error sequence 0, D, 0 gives the output sequence T1, T1+2D, T1+D, which is the deadbeat response to a period step of D.
- R4: A strobed error with |e| ≥ `thresh` is a spike. At that edge `interval_n` returns to 1, `locked` clears and the summed errors are discarded. The spike error itself is applied unscaled, as in base mode.
- R5: Each run of 4 consecutive evaluations with no spike doubles `interval_n`, up to a ceiling of 16, and sets `locked`.
- R6: With `interval_n` = n > 1, the first n−1 strobes of each interval leave `ctrl_word` unchanged and only add their errors to a sum.
- R7: On the n-th strobe, the sum of the n errors, shifted right arithmetically by log2(n) (rounding toward minus infinity), is applied as the error for the update.
- R8: The integrator, the error sum and `ctrl_word` saturate at the 24-bit two's complement limits (8388607 and −8388608) and do not wrap.
- R9: `interval_n` carries the factor n itself in binary, with exactly one bit set: 1, 2, 4, 8 or 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new phase-error sample |
| err_in | input | 16 | Signed phase error e(k) |
| thresh | input | 16 | Unsigned spike threshold on the error magnitude |
| centre | input | 24 | Signed nominal control word loaded at reset |
| ctrl_word | output | 24 | Signed oscillator control word u(k), registered |
| interval_n | output | 5 | Current interval factor n (1, 2, 4, 8, 16) |
| locked | output | 1 | High while the interval is stretched |

## Verification
The assertions check several properties on every cycle. A spike always returns the interval to 1 and clears the lock. The interval only ever grows by one doubling step or drops to 1, and it stays within its bound. `locked` implies a stretched interval. Hold strobes and cycles without a strobe never move the control word. The exact arithmetic can only be shown by the bench's scenarios: the three-sample deadbeat response to a step, the floored scaling of the error sum, the strobe counts at which n doubles, and saturation at the 24-bit limit.

// File: rtl/tofl_pkg.sv
package tofl_pkg;
  // classification of the current cycle's sample
  typedef enum logic [1:0] {
    SMP_IDLE  = 2'd0,  // no strobe
    SMP_HOLD  = 2'd1,  // strobe inside a stretched interval: sum only
    SMP_EVAL  = 2'd2,  // last strobe of an interval: update loop
    SMP_SPIKE = 2'd3   // error magnitude at or above threshold
  } smp_cls_t;

  localparam int STREAK_LEN = 4;  // calm evaluations needed per doubling
endpackage

// File: rtl/tofl_interval_ctl.sv
module tofl_interval_ctl
  import tofl_pkg::*;
#(
  parameter int EW    = 16,
  parameter int MAXSH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [EW-1:0] err,
  input  logic [EW-1:0]        thresh,
  output smp_cls_t             cls,
  output logic [$clog2(MAXSH+1)-1:0] sh,
  output logic [MAXSH:0]       n_fac,
  output logic                 locked
);
  localparam int SHW = $clog2(MAXSH+1);
  localparam int STW = $clog2(STREAK_LEN);
  localparam int NW  = MAXSH + 1;

  logic [SHW-1:0]   sh_q;
  logic [MAXSH-1:0] cnt_q;
  logic [STW-1:0]   streak_q;
  logic             locked_q;
  logic [EW-1:0]    mag;
  logic             big;
  logic             last;

  always_comb begin
    mag   = err[EW-1] ? EW'(-err) : EW'(err);
    big   = (mag >= thresh);
    n_fac = NW'(1) << sh_q;
    last  = (cnt_q == MAXSH'(n_fac - NW'(1)));
    if (!smp_valid)  cls = SMP_IDLE;
    else if (big)    cls = SMP_SPIKE;
    else if (last)   cls = SMP_EVAL;
    else             cls = SMP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      streak_q <= '0;
      locked_q <= 1'b0;
    end else begin
      case (cls)
        SMP_SPIKE: begin
          sh_q     <= '0;
          cnt_q    <= '0;
          streak_q <= '0;
          locked_q <= 1'b0;
        end
        SMP_HOLD: cnt_q <= cnt_q + MAXSH'(1);
        SMP_EVAL: begin
          cnt_q <= '0;
          if (streak_q == STW'(STREAK_LEN-1)) begin
            streak_q <= '0;
            locked_q <= 1'b1;
            if (sh_q < SHW'(MAXSH)) sh_q <= sh_q + SHW'(1);
          end else begin
            streak_q <= streak_q + STW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign sh     = sh_q;
  assign locked = locked_q;

  AST_SPIKE_DROPS_N: assert property (@(posedge clk) disable iff (rst)
    (cls == SMP_SPIKE) |=> (sh_q == '0 && !locked_q)); // R4
  AST_N_STEP_ONLY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sh_q == $past(sh_q) || sh_q == $past(sh_q) + SHW'(1) || sh_q == '0)); // R5
  AST_LOCK_STRETCHED: assert property (@(posedge clk) disable iff (rst)
    locked_q |-> (sh_q != '0)); // R5
  AST_N_BOUND: assert property (@(posedge clk) disable iff (rst)
    (sh_q <= SHW'(MAXSH)) && $onehot(n_fac)); // R9
endmodule

// File: rtl/tofl_err_scaler.sv
module tofl_err_scaler
  import tofl_pkg::*;
#(
  parameter int EW    = 16,
  parameter int AW    = 24,
  parameter int MAXSH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  smp_cls_t             cls,
  input  logic signed [EW-1:0] err,
  input  logic [$clog2(MAXSH+1)-1:0] sh,
  output logic signed [AW-1:0] eff
);
  localparam logic signed [AW+1:0] HI = {3'b000, {(AW-1){1'b1}}};
  localparam logic signed [AW+1:0] LO = {3'b111, {(AW-1){1'b0}}};

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] err_x;
  logic signed [AW+1:0] wide;
  logic signed [AW-1:0] sum;

  always_comb begin
    err_x = AW'(err);
    wide  = {{2{acc_q[AW-1]}}, acc_q} + {{2{err_x[AW-1]}}, err_x};
    if (wide > HI)      sum = HI[AW-1:0];
    else if (wide < LO) sum = LO[AW-1:0];
    else                sum = wide[AW-1:0];
    case (cls)
      SMP_SPIKE: eff = err_x;
      SMP_EVAL:  eff = sum >>> sh;
      default:   eff = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (cls == SMP_HOLD) acc_q <= sum;
    else if (cls == SMP_EVAL || cls == SMP_SPIKE) acc_q <= '0;
  end
endmodule

// File: rtl/tofl_freq_est.sv
module tofl_freq_est #(
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic signed [AW-1:0] eff,
  input  logic signed [AW-1:0] centre,
  output logic signed [AW-1:0] f_q
);
  localparam logic signed [AW+1:0] HI = {3'b000, {(AW-1){1'b1}}};
  localparam logic signed [AW+1:0] LO = {3'b111, {(AW-1){1'b0}}};

  logic signed [AW+1:0] wide;
  logic signed [AW-1:0] f_d;

  always_comb begin
    wide = {{2{f_q[AW-1]}}, f_q} + {{2{eff[AW-1]}}, eff};
    if (wide > HI)      f_d = HI[AW-1:0];
    else if (wide < LO) f_d = LO[AW-1:0];
    else                f_d = wide[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      f_q <= centre;
    else if (upd) f_q <= f_d;
  end

  AST_F_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(f_q)); // R6
endmodule

// File: rtl/tofl_phase_reg.sv
module tofl_phase_reg #(
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic signed [AW-1:0] f_prev,
  input  logic signed [AW-1:0] eff,
  input  logic signed [AW-1:0] centre,
  output logic signed [AW-1:0] u_q
);
  localparam logic signed [AW+1:0] HI = {3'b000, {(AW-1){1'b1}}};
  localparam logic signed [AW+1:0] LO = {3'b111, {(AW-1){1'b0}}};

  logic signed [AW+1:0] wide;
  logic signed [AW-1:0] u_d;

  // reload from the previous integrator value, then step by twice the error
  always_comb begin
    wide = {{2{f_prev[AW-1]}}, f_prev} + ({{2{eff[AW-1]}}, eff} <<< 1);
    if (wide > HI)      u_d = HI[AW-1:0];
    else if (wide < LO) u_d = LO[AW-1:0];
    else                u_d = wide[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      u_q <= centre;
    else if (upd) u_q <= u_d;
  end
endmodule

// File: rtl/tofl_top.sv
module tofl_top
  import tofl_pkg::*;
#(
  parameter int EW    = 16,
  parameter int AW    = 24,
  parameter int MAXSH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [EW-1:0] err_in,
  input  logic [EW-1:0]        thresh,
  input  logic signed [AW-1:0] centre,
  output logic signed [AW-1:0] ctrl_word,
  output logic [MAXSH:0]       interval_n,
  output logic                 locked
);
  localparam int SHW = $clog2(MAXSH+1);

  smp_cls_t             cls;
  logic [SHW-1:0]       sh;
  logic signed [AW-1:0] eff;
  logic signed [AW-1:0] f_q;
  logic                 upd;

  tofl_interval_ctl #(.EW(EW), .MAXSH(MAXSH)) u_ctl (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .err(err_in),
    .thresh(thresh), .cls(cls), .sh(sh), .n_fac(interval_n), .locked(locked)
  );

  tofl_err_scaler #(.EW(EW), .AW(AW), .MAXSH(MAXSH)) u_scl (
    .clk(clk), .rst(rst), .cls(cls), .err(err_in), .sh(sh), .eff(eff)
  );

  assign upd = (cls == SMP_EVAL) || (cls == SMP_SPIKE);

  tofl_freq_est #(.AW(AW)) u_fe (
    .clk(clk), .rst(rst), .upd(upd), .eff(eff), .centre(centre), .f_q(f_q)
  );

  tofl_phase_reg #(.AW(AW)) u_pr (
    .clk(clk), .rst(rst), .upd(upd), .f_prev(f_q), .eff(eff),
    .centre(centre), .u_q(ctrl_word)
  );

  AST_HOLD_KEEPS_U: assert property (@(posedge clk) disable iff (rst)
    (cls == SMP_HOLD) |=> $stable(ctrl_word)); // R6
  AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(ctrl_word) && $stable(interval_n) && $stable(locked))); // R2
endmodule

// File: tb/tofl_top_tb.sv
module tofl_top_tb;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               smp_valid = 1'b0;
  logic signed [15:0] err_in = '0;
  logic [15:0]        thresh = 16'd100;
  logic signed [23:0] centre = 24'sd1000;
  logic signed [23:0] ctrl_word;
  logic [4:0]         interval_n;
  logic               locked;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tofl_top u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .err_in(err_in),
    .thresh(thresh), .centre(centre), .ctrl_word(ctrl_word),
    .interval_n(interval_n), .locked(locked)
  );

  // table: threshold 100, centre 1000; R3 step in rows 0..2, spikes rows 3..4,
  // doubling after row 8, hold/eval with floor shift rows 9..12
  localparam int NV = 13;
  localparam int VE [NV] = '{0, 50, 0, 200, -300, 0, -20, 0, 0, 10, 6, -4, -3};
  localparam int VU [NV] = '{1000, 1100, 1050, 1450, 650, 950, 910, 930, 930,
                             930, 946, 946, 930};
  localparam int VN [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 2, 2, 2, 2, 2};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int e);
    smp_valid = 1'b1;
    err_in    = 16'(e);
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    err_in    = '0;
  endtask

  task automatic do_reset(input int c);
    centre = 24'(c);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset(1000);
    chk(ctrl_word == 24'sd1000, "R1 ctrl_word", int'(ctrl_word), 1000);
    chk(interval_n == 5'd1, "R1 interval_n", int'(interval_n), 1);
    chk(locked == 1'b0, "R1 locked", int'(locked), 0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      strobe(VE[i]);
      chk(int'(ctrl_word) == VU[i], (i < 3) ? "R3 step seq" : "R2/R6/R7 ctrl_word",
          int'(ctrl_word), VU[i]);
      chk(int'(interval_n) == VN[i], "R5/R9 interval_n", int'(interval_n), VN[i]);
    end
    chk(locked == 1'b1, "R5 locked after doubling", int'(locked), 1);

    // R2: no strobe -> a large error on err_in is ignored
    err_in = 16'sd5000;
    repeat (4) @(negedge clk);
    err_in = '0;
    chk(int'(ctrl_word) == 930, "R2 idle ctrl_word", int'(ctrl_word), 930);
    chk(interval_n == 5'd2, "R2 idle interval_n", int'(interval_n), 2);

    // R4: spike resets stretch and lock
    strobe(500);
    chk(interval_n == 5'd1, "R4 spike interval_n", int'(interval_n), 1);
    chk(locked == 1'b0, "R4 spike locked", int'(locked), 0);

    // R5: doubling schedule under a constant small error
    for (int k = 1; k <= 100; k++) begin
      strobe(2);
      if (k == 3)  chk(interval_n == 5'd1,  "R5 n after 3",   int'(interval_n), 1);
      if (k == 4)  chk(interval_n == 5'd2,  "R5 n after 4",   int'(interval_n), 2);
      if (k == 12) chk(interval_n == 5'd4,  "R5 n after 12",  int'(interval_n), 4);
      if (k == 28) chk(interval_n == 5'd8,  "R5 n after 28",  int'(interval_n), 8);
      if (k == 60) chk(interval_n == 5'd16, "R5 n after 60",  int'(interval_n), 16);
    end
    chk(interval_n == 5'd16, "R5 ceiling 16", int'(interval_n), 16);
    chk(locked == 1'b1, "R5 locked at ceiling", int'(locked), 1);

    // R4: spike in the middle of a 16-sample interval
    for (int k = 0; k < 5; k++) strobe(1);
    strobe(-150);
    chk(interval_n == 5'd1, "R4 mid-interval spike n", int'(interval_n), 1);
    chk(locked == 1'b0, "R4 mid-interval spike lock", int'(locked), 0);

    // R8: saturation at the positive limit and recovery
    do_reset(8388597);
    strobe(30000);
    chk(int'(ctrl_word) == 8388607, "R8 sat high", int'(ctrl_word), 8388607);
    strobe(-30000);
    chk(int'(ctrl_word) == 8328607, "R8 after sat", int'(ctrl_word), 8328607);

    // R8: saturation at the negative limit
    do_reset(-8388600);
    strobe(-30000);
    chk(int'(ctrl_word) == -8388608, "R8 sat low", int'(ctrl_word), -8388608);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule